// File: doc/BRIEF.md
# Push-Button Power Sequencing Controller

This block is the digital on/off controller of a power-management unit. It watches an active-low push-button, a flag from the supply monitor that reports the system supply is below its undervoltage threshold, and a hold input driven by the application processor. A press that stays low without a break for longer than the debounce interval, with the supply valid, moves the unit out of OFF. The block then raises, in order, a supply-ramp request, a one-cycle register-default request and a rail start-up request.

While the unit is on, a release of the button turns it off unless the hold input was raised first. An undervoltage report turns it off at once, whatever the other inputs are doing. A press held for the long-press interval drives the active-low power-good output low for a short pulse and requests a register restore. This happens once per continuous press, and the timer re-arms only on release. The block also keeps an undervoltage-threshold selection. It accepts writes while on and returns it to its default on every return to OFF.

All intervals are cycle counts. By default they are derived from a clock-frequency parameter (50 ms, 15 s, 0.5 ms), and each count can be overridden for a short simulation time base.

Top module: `pb_power_ctl`

## Requirements
- R1: From OFF, the `on` output rises exactly DEB_CYC+3 clock edges after `pb_n` goes low and stays low, provided `sys_low` is 0. A press that lasts fewer than DEB_CYC+1 clock edges never turns the unit on.
- R2: On power-up, `on` and `sys_ramp_req` rise first. One edge later `regs_default` is high for exactly one cycle. On the edge after that, `rails_start_req` and `pgood` rise.
- R3: While on, if `pb_n` is high and `hold` is low, `on` falls 3 edges after the input change.
- R4: While on, `sys_low` = 1 makes `on` fall 3 edges after the input change, even with the button pressed and `hold` high. While `sys_low` is 1, a press never turns the unit on.
- R5: If `hold` is high when the button is released, the unit stays on, and `pgood` and `rails_start_req` remain high.
- R6: With the unit running, `pgood` goes low LONG_CYC+2 edges after the press began and stays low for exactly PULSE_CYC cycles.
- R7: A continuous press of twice the long-press interval or more gives a single `pgood` pulse and a single long-press `regs_default` pulse.
- R8: The long-press timer re-arms only after the button is released. A new press then produces a new pulse at the same offset.
- R9: The long-press `regs_default` pulse lasts one cycle and is asserted in the same cycle that `pgood` first goes low.
- R10: `thr_sel` takes `thr_din` one edge after a `thr_wr` cycle while the unit is on. A write while OFF is ignored. `thr_sel` returns to 0 after the unit goes OFF.
- R11: Each input passes through two flip-flops. A one-cycle high glitch on `pb_n` restarts the debounce count, so turn-on comes DEB_CYC+3 edges after the button goes low again.
- R12: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_n | input | 1 | Push-button, low when pressed |
| hold | input | 1 | Processor keep-on request |
| sys_low | input | 1 | High when the system supply is below its threshold |
| thr_wr | input | 1 | Write strobe for the threshold selection |
| thr_din | input | THR_W | Threshold selection write data |
| on | output | 1 | Unit is in the ON state |
| sys_ramp_req | output | 1 | Request to ramp the system supply |
| rails_start_req | output | 1 | Request for ordered converter/regulator start-up |
| pgood | output | 1 | Power-good/reset, active low |
| regs_default | output | 1 | One-cycle request to restore register defaults |
| thr_sel | output | THR_W | Current undervoltage-threshold selection |

## Verification
Every result comes a fixed number of edges after the input change that causes it. Two synchronizer stages come first. Power-up follows at DEB_CYC+3 edges. The defaults request comes one edge after that, and the rails one edge later again. Shutdown takes 3 edges. The power-good pulse starts at LONG_CYC+2 edges from the press and lasts PULSE_CYC cycles. The bench drives and samples on falling edges and counts rising edges from each stimulus. During the long-press runs it compares `pgood` and `regs_default` against a computed expectation on every cycle. The press-length sweep checks the boundary just below and at the debounce count.

// File: rtl/pb_power_ctl.sv
module pb_power_ctl #(
  parameter int CLK_HZ    = 1_000_000,
  parameter int DEB_CYC   = CLK_HZ / 20,
  parameter int LONG_CYC  = CLK_HZ * 15,
  parameter int PULSE_CYC = CLK_HZ / 2000,
  parameter int THR_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pb_n,
  input  logic             hold,
  input  logic             sys_low,
  input  logic             thr_wr,
  input  logic [THR_W-1:0] thr_din,
  output logic             on,
  output logic             sys_ramp_req,
  output logic             rails_start_req,
  output logic             pgood,
  output logic             regs_default,
  output logic [THR_W-1:0] thr_sel
);

  localparam int DW = $clog2(DEB_CYC + 1);
  localparam int LW = $clog2(LONG_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);

  typedef enum logic [1:0] {S_OFF, S_RAMP, S_LOAD, S_RUN} st_t;

  st_t           st;
  logic [1:0]    pb_q, hold_q, low_q;
  logic          pb_s, hold_s, low_s;
  logic [DW-1:0] deb_cnt;
  logic [LW-1:0] lp_cnt;
  logic [PW-1:0] pl_cnt;
  logic          lp_fire, lp_fire_q;

  // R11: two-stage synchronizers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pb_q   <= 2'b11;
      hold_q <= 2'b00;
      low_q  <= 2'b11;
    end else begin
      pb_q   <= {pb_q[0], pb_n};
      hold_q <= {hold_q[0], hold};
      low_q  <= {low_q[0], sys_low};
    end

  assign pb_s   = pb_q[1];
  assign hold_s = hold_q[1];
  assign low_s  = low_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          deb_cnt <= '0;
    else if (pb_s)                       deb_cnt <= '0;
    else if (deb_cnt != DW'(DEB_CYC))    deb_cnt <= deb_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          lp_cnt <= '0;
    else if (pb_s)                       lp_cnt <= '0;
    else if (lp_cnt != LW'(LONG_CYC))    lp_cnt <= lp_cnt + 1'b1;

  assign lp_fire = !pb_s && (lp_cnt == LW'(LONG_CYC - 1)) && (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_OFF;
    else case (st)
      S_OFF:   if (!pb_s && deb_cnt == DW'(DEB_CYC) && !low_s) st <= S_RAMP;
      default: if (low_s || (pb_s && !hold_s)) st <= S_OFF;
               else if (st == S_RAMP)          st <= S_LOAD;
               else                            st <= S_RUN;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pl_cnt    <= '0;
      lp_fire_q <= 1'b0;
    end else begin
      lp_fire_q <= lp_fire;
      if (st == S_OFF)       pl_cnt <= '0;
      else if (lp_fire)      pl_cnt <= PW'(PULSE_CYC);
      else if (pl_cnt != 0)  pl_cnt <= pl_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              thr_sel <= '0;
    else if (st == S_OFF)    thr_sel <= '0;
    else if (thr_wr)         thr_sel <= thr_din;

  assign on              = (st != S_OFF);
  assign sys_ramp_req    = on;
  assign rails_start_req = (st == S_RUN);
  assign pgood           = (st == S_RUN) && (pl_cnt == '0);
  assign regs_default    = (st == S_LOAD) || lp_fire_q;

  // R1
  power_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on) |-> $past(!low_s && !pb_s));

  // R2
  rails_after_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rails_start_req) |-> $past(regs_default));

  // R4
  uv_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && low_s) |=> !on);

  // R9
  pulse_with_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pgood) && on) |-> regs_default);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pb_s && lp_cnt == LW'(LONG_CYC) && pl_cnt == '0) |=> (pl_cnt == '0));

  // R10
  thr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (thr_sel == '0));

endmodule

// File: tb/test_pb_power_ctl.sv
`timescale 1ns/1ps
module test_pb_power_ctl;
  localparam int D = 8;
  localparam int L = 40;
  localparam int P = 4;

  logic clk = 0, rst_n = 0, pb_n = 1, hold = 0, sys_low = 0, thr_wr = 0;
  logic [1:0] thr_din = '0;
  logic on, sys_ramp_req, rails_start_req, pgood, regs_default;
  logic [1:0] thr_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pb_power_ctl #(.CLK_HZ(1000), .DEB_CYC(D), .LONG_CYC(L), .PULSE_CYC(P), .THR_W(2)) i_pb_power_ctl (
    .clk(clk), .rst_n(rst_n), .pb_n(pb_n), .hold(hold), .sys_low(sys_low),
    .thr_wr(thr_wr), .thr_din(thr_din), .on(on), .sys_ramp_req(sys_ramp_req),
    .rails_start_req(rails_start_req), .pgood(pgood), .regs_default(regs_default),
    .thr_sel(thr_sel));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic go_off();
    hold = 0; pb_n = 1; sys_low = 0;
    step(D + 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    // R12 reset state
    chk("R12 on", on, 0); chk("R12 pgood", pgood, 0);
    chk("R12 ramp", sys_ramp_req, 0); chk("R12 rails", rails_start_req, 0);
    chk("R12 regs_default", regs_default, 0); chk("R12 thr_sel", thr_sel, 0);
    rst_n = 1;
    step(4);

    // R1 press-length sweep around the debounce boundary
    for (int lp = 1; lp <= D + 3; lp++) begin
      int seen = 0;
      pb_n = 0;
      for (int s = 0; s < lp; s++) begin step(1); if (on) seen = 1; end
      pb_n = 1;
      for (int s = 0; s < 6; s++) begin step(1); if (on) seen = 1; end
      chk($sformatf("R1 sweep len %0d", lp), seen, (lp >= D + 1) ? 1 : 0);
      go_off();
    end

    // R1 / R2 exact power-up timing and ordering
    pb_n = 0;
    step(D + 2);
    chk("R1 on before", on, 0);
    step(1);
    chk("R1 on", on, 1); chk("R2 ramp", sys_ramp_req, 1);
    chk("R2 no defaults yet", regs_default, 0); chk("R2 no rails yet", rails_start_req, 0);
    step(1);
    chk("R2 defaults", regs_default, 1); chk("R2 rails still off", rails_start_req, 0);
    step(1);
    chk("R2 rails", rails_start_req, 1); chk("R2 pgood", pgood, 1);
    chk("R2 defaults one cycle", regs_default, 0);

    // R3 release with hold low
    pb_n = 1;
    step(2); chk("R3 on still", on, 1);
    step(1); chk("R3 off", on, 0); chk("R3 pgood low", pgood, 0);
    go_off();

    // R11 glitch restarts debounce
    pb_n = 0; step(D);
    pb_n = 1; step(1);
    pb_n = 0;
    step(D + 2); chk("R11 on before", on, 0);
    step(1); chk("R11 on", on, 1);
    go_off();

    // R4 press with supply low never turns on
    begin
      int seen = 0;
      sys_low = 1; step(3);
      pb_n = 0;
      for (int s = 0; s < D + 12; s++) begin step(1); if (on) seen = 1; end
      chk("R4 no power-up when low", seen, 0);
      go_off();
    end

    // R6 R7 R9 cycle-by-cycle long press over twice the interval
    begin
      int npulse = 0, ndef = 0;
      pb_n = 0;
      for (int s = 1; s <= 2 * L + 12; s++) begin
        step(1);
        if (s == D + 4) hold = 1;
        chk($sformatf("R6 pgood s=%0d", s), pgood,
            ((s >= D + 5) && !(s >= L + 2 && s < L + 2 + P)) ? 1 : 0);
        chk($sformatf("R9 regs_default s=%0d", s), regs_default,
            ((s == D + 4) || (s == L + 2)) ? 1 : 0);
        if (s > D + 4 && regs_default) ndef++;
        if (s > D + 5 && !pgood) npulse++;
      end
      chk("R7 pgood low cycles", npulse, P);
      chk("R7 restore count", ndef, 1);
    end

    // R5 release with hold high keeps the unit on
    pb_n = 1; step(6);
    chk("R5 on", on, 1); chk("R5 pgood", pgood, 1); chk("R5 rails", rails_start_req, 1);

    // R8 re-press re-arms the long-press timer
    pb_n = 0;
    step(L + 1); chk("R8 pgood before", pgood, 1);
    step(1); chk("R8 pgood low", pgood, 0); chk("R8 restore", regs_default, 1);
    step(P); chk("R8 pgood back", pgood, 1);
    pb_n = 1; step(4);

    // R10 threshold retained while on, cleared at OFF, write in OFF ignored
    thr_din = 2'd3; thr_wr = 1; step(1); thr_wr = 0;
    chk("R10 written", thr_sel, 3);
    step(5); chk("R10 retained", thr_sel, 3);
    // R4 undervoltage shutdown with button pressed and hold high
    pb_n = 0; step(2);
    sys_low = 1;
    step(2); chk("R4 on still", on, 1);
    step(1); chk("R4 off", on, 0);
    step(2); chk("R10 cleared", thr_sel, 0);
    sys_low = 0; pb_n = 1; hold = 0; step(3);
    thr_din = 2'd2; thr_wr = 1; step(1); thr_wr = 0;
    step(1); chk("R10 write ignored off", thr_sel, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule